// File: doc/BRIEF.md
# Busy-Gated Memory Window

This block sits between a word-addressed register bus and the two single-port memories of an accelerator: one holding instructions and one holding data. Each memory is reached through its own 16 KiB region of the bus address space. The block decodes which region a request falls in and converts the byte address into a word index. It forwards the request to the matching memory only when the accelerator reports that it is idle.

When the accelerator is busy or locked, the block keeps the memories out of reach. Reads return zero and writes never reach a memory. A request that touches either region while the accelerator is busy also raises a one-cycle fatal flag. A controller uses that flag to lock the accelerator. A request made while the accelerator is locked gets the same zero response but raises no further flag.

Every request receives exactly one response, one cycle later. For a read of an implemented word, the response carries the word the memory returns in that cycle.

Top module: `memwin_gate`

## Requirements
- R1: Each cycle with `req_valid_i` high is followed one cycle later by `rsp_valid_o` high for one cycle. A cycle without a request is followed by `rsp_valid_o` low.
- R2: The instruction region covers byte addresses 0x4000 to 0x7FFF. When idle, an aligned access to 0x4000+4n with n below 1024 drives `imem_req_o` with address n. A read returns `imem_rdata_i` in the response cycle.
- R3: The data region covers byte addresses 0x8000 to 0xBFFF. Only words n below 512 are reachable, and they map to data memory address n. The top bit of `dmem_addr_o` is never driven high with a strobe.
- R4: Inside a region but past the implemented words (instruction offset 0x1000 and above, data offset 0x800 and above), a request strobes no memory and reads zero. It raises no flag when idle.
- R5: A write reaches memory only when all four bits of `req_be_i` are 1. Any other byte-enable pattern drops the write with no strobe, so the target word keeps its old value.
- R6: The state input is encoded as idle = 2'b00, busy = 2'b01 and locked = 2'b10; 2'b11 acts as locked. In any non-idle state no memory is strobed and every response reads zero.
- R7: When busy, a read or a write anywhere in either 16 KiB region raises `fatal_bus_o` for one cycle, in the response cycle. This includes words past the implemented ones and misaligned addresses.
- R8: `fatal_bus_o` stays low whenever the request cycle was not busy, including locked and 2'b11.
- R9: Requests outside both regions strobe no memory, read zero and raise no flag in any state.
- R10: While `rst_ni` is low, `rsp_valid_o` and `fatal_bus_o` are low.
- R11: A request whose address bits [1:0] are not zero is treated like an unimplemented word: no strobe and a zero read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_state_i | input | 2 | Accelerator state (00 idle, 01 busy, 10/11 locked) |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (16) | Byte address |
| req_be_i | input | DATA_W/8 (4) | Byte enables; only all-ones allows a write |
| req_wdata_i | input | DATA_W (32) | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | DATA_W (32) | Read data, zero when blocked or unmapped |
| fatal_bus_o | output | 1 | Pulse: access made while busy |
| imem_req_o | output | 1 | Instruction memory strobe |
| imem_we_o | output | 1 | Instruction memory write enable |
| imem_addr_o | output | 10 | Instruction memory word address |
| imem_wdata_o | output | DATA_W (32) | Instruction memory write data |
| imem_rdata_i | input | DATA_W (32) | Instruction memory read data, one cycle after the strobe |
| dmem_req_o | output | 1 | Data memory strobe |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_addr_o | output | 10 | Data memory word address |
| dmem_wdata_o | output | DATA_W (32) | Data memory write data |
| dmem_rdata_i | input | DATA_W (32) | Data memory read data, one cycle after the strobe |

## Verification
The bench attacks the edges of each region: the last implemented word, the first word past it, and the data window's 512-word limit inside a 1024-word memory. A decoder that is off by one there would either strobe a memory that should stay untouched or return zero for a real word. Writes with partial byte enables and writes made while busy or locked are followed by idle reads of the same word, so a leaking gate shows up as corrupted contents. State changes from one request to the next and the reserved 2'b11 code check that the fatal flag follows only the busy cycle. A design that also flagged accesses while locked, or accesses outside both regions, would pulse where the model expects silence.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'b00,
        ACC_BUSY   = 2'b01,
        ACC_LOCKED = 2'b10,
        ACC_RSVD   = 2'b11
    } acc_state_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'b00,
        SRC_IMEM = 2'b01,
        SRC_DMEM = 2'b10
    } rsp_src_e;

    typedef struct packed {
        logic     valid;
        rsp_src_e src;
        logic     fatal;
    } rsp_stage_t;

endpackage

// File: rtl/memwin_window.sv
module memwin_window #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned REGION_AW = 14,
    parameter int unsigned WORDS     = 1024,
    parameter int unsigned MEM_AW    = 10,
    parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              impl_o,
    output logic [MEM_AW-1:0] mem_addr_o
);
    localparam int unsigned IDX_W = REGION_AW - 2;
    localparam logic [IDX_W:0] LIMIT = WORDS[IDX_W:0];

    logic [IDX_W-1:0] idx;
    logic             aligned;

    always_comb begin
        idx        = addr_i[REGION_AW-1:2];
        aligned    = (addr_i[1:0] == 2'b00);
        hit_o      = (addr_i[ADDR_W-1:REGION_AW] == BASE[ADDR_W-1:REGION_AW]);
        impl_o     = aligned && ({1'b0, idx} < LIMIT);
        mem_addr_o = idx[MEM_AW-1:0];
    end

endmodule

// File: rtl/memwin_resp.sv
module memwin_resp
    import memwin_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  rsp_src_e          src_i,
    input  logic              fatal_i,
    input  logic [DATA_W-1:0] imem_rdata_i,
    input  logic [DATA_W-1:0] dmem_rdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              fatal_o
);
    rsp_stage_t stage_d, stage_q;

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = valid_i;
        stage_d.src   = valid_i ? src_i : SRC_ZERO;
        stage_d.fatal = valid_i && fatal_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '{valid: 1'b0, src: SRC_ZERO, fatal: 1'b0};
        end else begin
            stage_q <= stage_d;
        end
    end

    always_comb begin
        rsp_valid_o = stage_q.valid;
        fatal_o     = stage_q.fatal;
        unique case (stage_q.src)
            SRC_IMEM: rsp_rdata_o = imem_rdata_i;
            SRC_DMEM: rsp_rdata_o = dmem_rdata_i;
            default:  rsp_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/memwin_gate.sv
module memwin_gate
    import memwin_pkg::*;
#(
    parameter int unsigned ADDR_W         = 16,
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned REGION_BYTES   = 16384,
    parameter logic [ADDR_W-1:0] IMEM_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] DMEM_BASE = 16'h8000,
    parameter int unsigned IMEM_WORDS     = 1024,
    parameter int unsigned DMEM_WIN_WORDS = 512,
    parameter int unsigned DMEM_DEPTH     = 1024,
    localparam int unsigned BE_W      = DATA_W / 8,
    localparam int unsigned REGION_AW = $clog2(REGION_BYTES),
    localparam int unsigned IMEM_AW   = $clog2(IMEM_WORDS),
    localparam int unsigned DMEM_AW   = $clog2(DMEM_DEPTH)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         acc_state_i,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [BE_W-1:0]    req_be_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    output logic               rsp_valid_o,
    output logic [DATA_W-1:0]  rsp_rdata_o,
    output logic               fatal_bus_o,
    output logic               imem_req_o,
    output logic               imem_we_o,
    output logic [IMEM_AW-1:0] imem_addr_o,
    output logic [DATA_W-1:0]  imem_wdata_o,
    input  logic [DATA_W-1:0]  imem_rdata_i,
    output logic               dmem_req_o,
    output logic               dmem_we_o,
    output logic [DMEM_AW-1:0] dmem_addr_o,
    output logic [DATA_W-1:0]  dmem_wdata_o,
    input  logic [DATA_W-1:0]  dmem_rdata_i
);
    logic     imem_hit, imem_impl;
    logic     dmem_hit, dmem_impl;
    logic     is_idle, is_busy, write_ok;
    logic     imem_go, dmem_go;
    rsp_src_e src_sel;
    logic     fatal_now;

    memwin_window #(
        .ADDR_W   (ADDR_W),
        .REGION_AW(REGION_AW),
        .WORDS    (IMEM_WORDS),
        .MEM_AW   (IMEM_AW),
        .BASE     (IMEM_BASE)
    ) u_imem_win (
        .addr_i    (req_addr_i),
        .hit_o     (imem_hit),
        .impl_o    (imem_impl),
        .mem_addr_o(imem_addr_o)
    );

    memwin_window #(
        .ADDR_W   (ADDR_W),
        .REGION_AW(REGION_AW),
        .WORDS    (DMEM_WIN_WORDS),
        .MEM_AW   (DMEM_AW),
        .BASE     (DMEM_BASE)
    ) u_dmem_win (
        .addr_i    (req_addr_i),
        .hit_o     (dmem_hit),
        .impl_o    (dmem_impl),
        .mem_addr_o(dmem_addr_o)
    );

    always_comb begin
        is_idle  = (acc_state_e'(acc_state_i) == ACC_IDLE);
        is_busy  = (acc_state_e'(acc_state_i) == ACC_BUSY);
        write_ok = !req_write_i || (&req_be_i);

        imem_go = req_valid_i && is_idle && imem_hit && imem_impl && write_ok;
        dmem_go = req_valid_i && is_idle && dmem_hit && dmem_impl && write_ok;

        imem_req_o   = imem_go;
        imem_we_o    = imem_go && req_write_i;
        imem_wdata_o = req_wdata_i;
        dmem_req_o   = dmem_go;
        dmem_we_o    = dmem_go && req_write_i;
        dmem_wdata_o = req_wdata_i;

        if (imem_go && !req_write_i) begin
            src_sel = SRC_IMEM;
        end else if (dmem_go && !req_write_i) begin
            src_sel = SRC_DMEM;
        end else begin
            src_sel = SRC_ZERO;
        end

        fatal_now = is_busy && (imem_hit || dmem_hit);
    end

    memwin_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .valid_i     (req_valid_i),
        .src_i       (src_sel),
        .fatal_i     (fatal_now),
        .imem_rdata_i(imem_rdata_i),
        .dmem_rdata_i(dmem_rdata_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .fatal_o     (fatal_bus_o)
    );

endmodule

// File: rtl/memwin_gate_chk.sv
module memwin_gate_chk #(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned REGION_BYTES = 16384,
    parameter logic [ADDR_W-1:0] IMEM_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] DMEM_BASE = 16'h8000,
    parameter int unsigned DMEM_DEPTH   = 1024,
    localparam int unsigned BE_W      = DATA_W / 8,
    localparam int unsigned REGION_AW = $clog2(REGION_BYTES),
    localparam int unsigned DMEM_AW   = $clog2(DMEM_DEPTH)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [1:0]         acc_state_i,
    input logic               req_valid_i,
    input logic               req_write_i,
    input logic [ADDR_W-1:0]  req_addr_i,
    input logic [BE_W-1:0]    req_be_i,
    input logic               rsp_valid_o,
    input logic [DATA_W-1:0]  rsp_rdata_o,
    input logic               fatal_bus_o,
    input logic               imem_req_o,
    input logic               dmem_req_o,
    input logic [DMEM_AW-1:0] dmem_addr_o
);
    logic in_region;
    assign in_region = (req_addr_i[ADDR_W-1:REGION_AW] == IMEM_BASE[ADDR_W-1:REGION_AW])
                    || (req_addr_i[ADDR_W-1:REGION_AW] == DMEM_BASE[ADDR_W-1:REGION_AW]);

    p_rsp_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);
    p_no_rsp_without_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);
    p_single_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({imem_req_o, dmem_req_o}));
    p_dmem_lower_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dmem_req_o |-> !dmem_addr_o[DMEM_AW-1]);
    p_partial_write_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && !(&req_be_i)) |-> !(imem_req_o || dmem_req_o));
    p_mem_only_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imem_req_o || dmem_req_o) |-> (acc_state_i == 2'b00));
    p_blocked_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && acc_state_i != 2'b00) |=> (rsp_rdata_o == '0));
    p_busy_access_fatal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && acc_state_i == 2'b01 && in_region) |=> fatal_bus_o);
    p_no_fatal_unless_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_state_i != 2'b01) |=> !fatal_bus_o);
    p_outside_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !in_region) |=> (!fatal_bus_o && rsp_rdata_o == '0));

endmodule

bind memwin_gate memwin_gate_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_BYTES(REGION_BYTES),
    .IMEM_BASE   (IMEM_BASE),
    .DMEM_BASE   (DMEM_BASE),
    .DMEM_DEPTH  (DMEM_DEPTH)
) u_memwin_gate_chk (.*);

// File: tb/memwin_gate_bench.sv
`timescale 1ns/1ps
module memwin_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_state = 2'b00;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, fatal_bus;
    logic [31:0] rsp_rdata;
    logic        imem_req, imem_we, dmem_req, dmem_we;
    logic [9:0]  imem_addr, dmem_addr;
    logic [31:0] imem_wdata, dmem_wdata;
    logic [31:0] imem_rdata = '0;
    logic [31:0] dmem_rdata = '0;

    always #4 clk = ~clk;

    memwin_gate u_memwin_gate (
        .clk_i(clk), .rst_ni(rst_n), .acc_state_i(acc_state),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_be_i(req_be), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .fatal_bus_o(fatal_bus),
        .imem_req_o(imem_req), .imem_we_o(imem_we), .imem_addr_o(imem_addr),
        .imem_wdata_o(imem_wdata), .imem_rdata_i(imem_rdata),
        .dmem_req_o(dmem_req), .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr),
        .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata)
    );

    // Memories behind the gate
    logic [31:0] mem_i [1024];
    logic [31:0] mem_d [1024];
    // Reference contents kept by the model
    logic [31:0] ref_i [1024];
    logic [31:0] ref_d [1024];

    always @(posedge clk) begin
        if (imem_req) begin
            if (imem_we) mem_i[imem_addr] <= imem_wdata;
            else         imem_rdata <= mem_i[imem_addr];
        end
        if (dmem_req) begin
            if (dmem_we) mem_d[dmem_addr] <= dmem_wdata;
            else         dmem_rdata <= mem_d[dmem_addr];
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Model state for the response due next cycle
    bit          p_valid = 0;
    logic [31:0] p_rdata = '0;
    bit          p_fatal = 0;
    string       p_tag = "R1";
    string       p_ftag = "R8";

    // Scratch for the current request
    int          region;
    int          word;
    bit          in_win, impl, go, e_im, e_dm;
    string       tag, ftag;
    logic [31:0] e_rd;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 0);
            check(fatal_bus == 1'b0, "R10", "fatal in reset", 32'(fatal_bus), 0);
            p_valid = 0;
            p_fatal = 0;
        end else begin
            check(rsp_valid == p_valid, "R1", "rsp_valid", 32'(rsp_valid), 32'(p_valid));
            if (p_valid)
                check(rsp_rdata == p_rdata, p_tag, "rsp_rdata", rsp_rdata, p_rdata);
            check(fatal_bus == p_fatal, p_ftag, "fatal", 32'(fatal_bus), 32'(p_fatal));

            region = int'(req_addr[15:14]);
            word   = int'(req_addr[13:2]);
            in_win = req_valid && (region == 1 || region == 2);
            impl   = (req_addr[1:0] == 2'b00) &&
                     ((region == 1 && word < 1024) || (region == 2 && word < 512));
            go     = in_win && impl && acc_state == 2'b00 && (!req_write || req_be == 4'hF);
            e_im   = go && region == 1;
            e_dm   = go && region == 2;
            e_rd   = '0;
            if (go && !req_write) e_rd = (region == 1) ? ref_i[word] : ref_d[word];
            if (go && req_write) begin
                if (region == 1) ref_i[word] = req_wdata;
                else             ref_d[word] = req_wdata;
            end

            if (!in_win)                   tag = "R9";
            else if (acc_state != 2'b00)   tag = "R6";
            else if (req_addr[1:0] != 0)   tag = "R11";
            else if (!impl)                tag = "R4";
            else if (req_write && req_be != 4'hF) tag = "R5";
            else if (region == 1)          tag = "R2";
            else                           tag = "R3";
            ftag = (acc_state == 2'b01) ? "R7" : "R8";
            if (!in_win) ftag = "R9";

            check(imem_req == e_im, tag, "imem_req", 32'(imem_req), 32'(e_im));
            check(dmem_req == e_dm, tag, "dmem_req", 32'(dmem_req), 32'(e_dm));
            if (e_im) begin
                check(imem_addr == word[9:0], "R2", "imem_addr", 32'(imem_addr), 32'(word));
                check(imem_we == req_write, "R2", "imem_we", 32'(imem_we), 32'(req_write));
            end
            if (e_dm) begin
                check(dmem_addr == word[9:0], "R3", "dmem_addr", 32'(dmem_addr), 32'(word));
                check(dmem_we == req_write, "R3", "dmem_we", 32'(dmem_we), 32'(req_write));
            end

            p_valid = req_valid;
            p_rdata = e_rd;
            p_fatal = in_win && acc_state == 2'b01;
            p_tag   = tag;
            p_ftag  = ftag;
        end
    end

    task automatic drive(input bit v, input bit w, input logic [15:0] a,
                         input logic [3:0] be, input logic [31:0] d, input logic [1:0] st);
        @(posedge clk);
        #1;
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_be    = be;
        req_wdata = d;
        acc_state = st;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem_i[i] = 32'hA000_0000 | i;
            ref_i[i] = 32'hA000_0000 | i;
            mem_d[i] = 32'hD000_0000 | i;
            ref_d[i] = 32'hD000_0000 | i;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: idle write and read-back, first and last implemented words
        drive(1, 1, 16'h4014, 4'hF, 32'h1234_5678, 2'b00);
        drive(1, 0, 16'h4014, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h4000, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h4FFC, 4'hF, 0, 2'b00);
        // R3: data window limits
        drive(1, 1, 16'h87FC, 4'hF, 32'hCAFE_F00D, 2'b00);
        drive(1, 0, 16'h87FC, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h8000, 4'hF, 0, 2'b00);
        // R4: beyond implemented words
        drive(1, 0, 16'h8800, 4'hF, 0, 2'b00);
        drive(1, 1, 16'h8800, 4'hF, 32'hBAD0_0001, 2'b00);
        drive(1, 0, 16'h5000, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h7FFC, 4'hF, 0, 2'b00);
        // R5: partial writes dropped, then read-back
        drive(1, 1, 16'h401C, 4'h7, 32'hFFFF_FFFF, 2'b00);
        drive(1, 1, 16'h801C, 4'h1, 32'hFFFF_FFFF, 2'b00);
        drive(1, 0, 16'h401C, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h801C, 4'hF, 0, 2'b00);
        // R11: misaligned
        drive(1, 0, 16'h4016, 4'hF, 0, 2'b00);
        // R9: outside both regions
        drive(1, 0, 16'h0010, 4'hF, 0, 2'b00);
        drive(1, 1, 16'hC000, 4'hF, 32'h1, 2'b01);
        drive(1, 0, 16'h3FFC, 4'hF, 0, 2'b10);
        // R7: busy accesses
        drive(1, 1, 16'h4014, 4'hF, 32'hDEAD_BEEF, 2'b01);
        drive(1, 0, 16'h800C, 4'hF, 0, 2'b01);
        drive(1, 0, 16'h8800, 4'hF, 0, 2'b01);
        drive(0, 0, 16'h4000, 4'hF, 0, 2'b01);
        // R6 and R8: locked and reserved code
        drive(1, 1, 16'h87FC, 4'hF, 32'hDEAD_BEEF, 2'b10);
        drive(1, 0, 16'h4000, 4'hF, 0, 2'b11);
        drive(1, 1, 16'h4000, 4'hF, 32'h0BAD_0BAD, 2'b11);
        // Confirm contents survived the blocked writes
        drive(1, 0, 16'h4014, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h87FC, 4'hF, 0, 2'b00);
        drive(1, 0, 16'h4000, 4'hF, 0, 2'b00);
        drive(0, 0, 16'h0000, 4'hF, 0, 2'b00);

        // Mixed traffic
        for (int k = 0; k < 600; k++) begin
            logic [15:0] a;
            logic [1:0]  st;
            int unsigned r;
            r = $urandom % 8;
            case (r)
                0, 1, 2: a = 16'h4000 | 16'(($urandom % 1100) << 2);
                3, 4, 5: a = 16'h8000 | 16'(($urandom % 600) << 2);
                6:       a = 16'($urandom);
                default: a = 16'h4000 | 16'(($urandom % 16) << 2) | 16'($urandom % 4);
            endcase
            r  = $urandom % 10;
            st = (r < 6) ? 2'b00 : 2'(r - 6);
            drive(($urandom % 5) != 0, ($urandom % 3) == 0, a,
                  (($urandom % 4) == 0) ? 4'($urandom) : 4'hF, $urandom, st);
        end
        drive(0, 0, 16'h0000, 4'hF, 0, 2'b00);
        repeat (3) @(posedge clk);
        done = 1;
        finish_run();
    end

endmodule